// File: doc/BRIEF.md
# GPIO Port with Per-Pin Peripheral Handover

This block owns a small group of chip pads (two to six pins) and decides, one pin at a time, who drives each pad. A pin can be run from a set of software-visible registers as a plain input or output. It can also be handed to an attached peripheral, which then supplies the pad's output value and output enable. For every pad the block produces three signals: an output value, an output enable and a pull-up enable. The pull-up is always removed while the pad is being driven.

Software reaches the block over a simple synchronous register bus with word addresses. There are four 16-bit registers at consecutive offsets: pin-ownership select at +0, direction at +1, data at +2 and pull-up at +3. Reset gives every pin to its peripheral with the pull-up on. Pad inputs pass through a two-stage synchroniser before they can be read back.

Top module: `gpio_port_mux`

## Requirements
- R1: Registers sit at word offsets +0 (ownership select), +1 (direction), +2 (data) and +3 (pull-up). A write strobe updates the addressed register at that clock edge. Read data appears on the cycle after the read strobe.
- R2: An ownership bit of 1 hands the pin to the peripheral. The pad output then equals the peripheral output, and the pad output enable equals the peripheral output-enable request, whatever the direction bit holds.
- R3: An ownership bit of 0 gives GPIO mode. In that mode a direction bit of 1 drives the pad from the data-register bit with output enable high. A direction bit of 0 leaves the output enable low.
- R4: The pad pull-up enable equals the pull-up bit ANDed with the inverse of the pad output enable, in both modes. A driving pad never has its pull-up on.
- R5: After reset the ownership and pull-up registers hold all ones, and the direction and data registers hold all zeros.
- R6: Register bits at or above the pin count have fixed read values. They read as 1 in the ownership and pull-up registers, read as 0 in the direction and data registers, and ignore writes.
- R7: A data-register read returns the stored output bit for each pin in GPIO mode with direction 1. Every other pin returns its synchronised pad input.
- R8: A change on a pad input is not seen by a read strobe at the first or second clock edge after the change. It is seen by a read strobe at the third edge.
- R9: Offsets +4 and above read as zero, and writes to them change no register.
- R10: The read-data port is zero on any cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | ADDR_W | Word offset from the port base |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| pad_in | input | NPINS | Raw pad input levels |
| periph_out | input | NPINS | Peripheral output values |
| periph_oe | input | NPINS | Peripheral output-enable requests |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| pad_pu | output | NPINS | Pad pull-up enables |

## Verification
The assertions assume that the bus never asserts read and write together, and that the address and write data are steady while a strobe is high. The bench drives every bus signal on the falling clock edge and runs one access at a time, so both assumptions hold. The peripheral inputs are changed only while no access is in flight. The pad inputs are treated as asynchronous, and the synchroniser latency is measured from the exact edge at which a new level is applied.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    localparam int unsigned REG_W = 16;

    typedef enum logic [1:0] {
        OFS_OWNER = 2'd0,
        OFS_DIR   = 2'd1,
        OFS_DATA  = 2'd2,
        OFS_PULL  = 2'd3
    } reg_ofs_e;

    typedef struct packed {
        logic out;
        logic oe;
        logic pu;
    } pad_ctl_t;

    // Per-pin selection between register control and peripheral control
    function automatic pad_ctl_t resolve_pad(
        input logic owner,
        input logic dir,
        input logic dat,
        input logic pull,
        input logic p_out,
        input logic p_oe
    );
        pad_ctl_t r;
        r.oe  = owner ? p_oe : dir;
        r.out = owner ? p_out : dat;
        r.pu  = pull & ~r.oe;
        return r;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

    // R8: the second stage only takes values the first stage held one cycle earlier
    stage_chain_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stage2_q == $past(stage1_q));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_mux_pkg::*;
#(
    parameter int unsigned NPINS  = 4,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [NPINS-1:0]  pin_sync,
    output logic [NPINS-1:0]  owner_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  data_q,
    output logic [NPINS-1:0]  pull_q,
    output logic [REG_W-1:0]  rdata
);
    localparam int unsigned FILL = REG_W - NPINS;
    localparam logic [ADDR_W-1:0] LAST_OFS = ADDR_W'(3);

    logic     in_range;
    reg_ofs_e ofs;
    logic [NPINS-1:0] gpio_drive;
    logic [NPINS-1:0] data_view;
    logic [REG_W-1:0] rd_mux;
    logic [REG_W-1:0] rdata_q;

    assign in_range = (addr <= LAST_OFS);
    assign ofs      = reg_ofs_e'(addr[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= '1;
            dir_q   <= '0;
            data_q  <= '0;
            pull_q  <= '1;
        end else if (wr && in_range) begin
            unique case (ofs)
                OFS_OWNER: owner_q <= wdata[NPINS-1:0];
                OFS_DIR:   dir_q   <= wdata[NPINS-1:0];
                OFS_DATA:  data_q  <= wdata[NPINS-1:0];
                OFS_PULL:  pull_q  <= wdata[NPINS-1:0];
                default:   ;
            endcase
        end
    end

    assign gpio_drive = ~owner_q & dir_q;
    assign data_view  = (gpio_drive & data_q) | (~gpio_drive & pin_sync);

    always_comb begin
        rd_mux = '0;
        if (in_range) begin
            unique case (ofs)
                OFS_OWNER: rd_mux = {{FILL{1'b1}}, owner_q};
                OFS_DIR:   rd_mux = {{FILL{1'b0}}, dir_q};
                OFS_DATA:  rd_mux = {{FILL{1'b0}}, data_view};
                OFS_PULL:  rd_mux = {{FILL{1'b1}}, pull_q};
                default:   rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= rd ? rd_mux : '0;
    end

    assign rdata = rdata_q;

    // R10
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd |=> rdata == '0);
    // R6
    owner_fill_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == ADDR_W'(0)) |=> &rdata[REG_W-1:NPINS]);
    // R6
    dir_fill_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == ADDR_W'(1)) |=> rdata[REG_W-1:NPINS] == '0);
    // R9
    oob_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && addr > LAST_OFS) |=>
            $stable(owner_q) && $stable(dir_q) && $stable(data_q) && $stable(pull_q));
    // R9
    oob_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && addr > LAST_OFS) |=> rdata == '0);
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_mux_pkg::*;
#(
    parameter int unsigned NPINS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] owner,
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] dat,
    input  logic [NPINS-1:0] pull,
    input  logic [NPINS-1:0] p_out,
    input  logic [NPINS-1:0] p_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_pu
);
    pad_ctl_t ctl [NPINS];

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign ctl[i]     = resolve_pad(owner[i], dir[i], dat[i], pull[i], p_out[i], p_oe[i]);
        assign pad_out[i] = ctl[i].out;
        assign pad_oe[i]  = ctl[i].oe;
        assign pad_pu[i]  = ctl[i].pu;

        // R3
        gpio_input_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            (!owner[i] && !dir[i]) |-> !pad_oe[i]);
        // R2
        periph_ignores_dir_chk: assert property (@(posedge clk) disable iff (rst)
            owner[i] |-> (pad_oe[i] == p_oe[i]) && (pad_out[i] == p_out[i]));
    end
endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux
    import gpio_mux_pkg::*;
#(
    parameter int unsigned NPINS  = 4,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    input  logic [NPINS-1:0]  periph_out,
    input  logic [NPINS-1:0]  periph_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pu
);
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] owner_q, dir_q, data_q, pull_q;

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .raw_in   (pad_in),
        .sync_out (pin_sync)
    );

    gpio_port_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .owner_q  (owner_q),
        .dir_q    (dir_q),
        .data_q   (data_q),
        .pull_q   (pull_q),
        .rdata    (bus_rdata)
    );

    gpio_pad_mux #(.NPINS(NPINS)) u_pads (
        .clk     (clk),
        .rst     (rst),
        .owner   (owner_q),
        .dir     (dir_q),
        .dat     (data_q),
        .pull    (pull_q),
        .p_out   (periph_out),
        .p_oe    (periph_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_pu  (pad_pu)
    );

    // R4
    drive_no_pull_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & pad_pu) == '0);
    // R5
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (pad_pu == pull_q) && (&owner_q || !rst));
endmodule

// File: tb/gpio_port_mux_tb_top.sv
`timescale 1ns/1ps
module gpio_port_mux_tb_top;
    localparam int unsigned N = 4;

    typedef struct packed {
        logic [3:0] own, dir, dat, pul, po, poe, e_out, e_oe, e_pu;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{4'hF, 4'h0, 4'h0, 4'hF, 4'hA, 4'h3, 4'hA, 4'h3, 4'hC},
        '{4'h0, 4'hF, 4'h5, 4'hF, 4'hA, 4'h0, 4'h5, 4'hF, 4'h0},
        '{4'h0, 4'h0, 4'h5, 4'hF, 4'h0, 4'hF, 4'h5, 4'h0, 4'hF},
        '{4'h0, 4'h3, 4'h6, 4'hA, 4'h0, 4'h0, 4'h6, 4'h3, 4'h8},
        '{4'hC, 4'h5, 4'h3, 4'hF, 4'h4, 4'h8, 4'h7, 4'h9, 4'h6},
        '{4'hA, 4'hF, 4'h0, 4'h5, 4'hF, 4'h0, 4'hA, 4'h5, 4'h0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [N-1:0] pad_in = '0, periph_out = '0, periph_oe = '0;
    logic [N-1:0] pad_out, pad_oe, pad_pu;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    gpio_port_mux #(.NPINS(N), .ADDR_W(3)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .periph_out(periph_out), .periph_oe(periph_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R5: reset state seen at the pads (peripheral owns all pins, pull-ups on)
        check("R5 pad_pu", 16'(pad_pu), 16'h000F);
        check("R5 pad_oe", 16'(pad_oe), 16'h0000);
        rd(3'd0, r); check("R5 R1 owner reg", r, 16'hFFFF);
        rd(3'd1, r); check("R5 dir reg", r, 16'h0000);
        rd(3'd3, r); check("R5 pull reg", r, 16'hFFFF);

        // R6: reserved bits fixed
        wr(3'd1, 16'hFFFF); rd(3'd1, r); check("R6 dir fill", r, 16'h000F);
        wr(3'd0, 16'h0000); rd(3'd0, r); check("R6 owner fill", r, 16'hFFF0);
        wr(3'd3, 16'h0000); rd(3'd3, r); check("R6 pull fill", r, 16'hFFF0);
        // R7: GPIO outputs read back the stored value
        wr(3'd2, 16'hFFFF); rd(3'd2, r); check("R7 R6 data out readback", r, 16'h000F);

        // R2 R3 R4: table walk
        for (int k = 0; k < 6; k++) begin
            wr(3'd0, {12'h000, VEC[k].own});
            wr(3'd1, {12'h000, VEC[k].dir});
            wr(3'd2, {12'h000, VEC[k].dat});
            wr(3'd3, {12'h000, VEC[k].pul});
            periph_out = VEC[k].po;
            periph_oe  = VEC[k].poe;
            #1;
            check("R2 R3 pad_out", 16'(pad_out), 16'(VEC[k].e_out));
            check("R2 R3 pad_oe",  16'(pad_oe),  16'(VEC[k].e_oe));
            check("R4 pad_pu",     16'(pad_pu),  16'(VEC[k].e_pu));
        end
        periph_out = '0; periph_oe = '0;

        // R7: mixed data view: pins 1:0 output stored 2'b10, pins 3:2 input
        wr(3'd0, 16'h0000); wr(3'd1, 16'h0003); wr(3'd2, 16'h0006);
        @(negedge clk); pad_in = 4'h9;
        repeat (3) @(negedge clk);
        rd(3'd2, r); check("R7 mixed data read", r, 16'h000A);

        // R8: synchroniser latency, all pins input
        wr(3'd1, 16'h0000);
        @(negedge clk);
        pad_in = 4'h6; bus_rd = 1'b1; bus_addr = 3'd2;
        @(negedge clk); check("R8 first edge old", bus_rdata, 16'h0009);
        @(negedge clk); check("R8 second edge old", bus_rdata, 16'h0009);
        @(negedge clk); check("R8 third edge new", bus_rdata, 16'h0006);
        bus_rd = 1'b0;

        // R9: out-of-range offsets
        wr(3'd5, 16'hFFFF); rd(3'd1, r); check("R9 write ignored", r, 16'h0000);
        rd(3'd0, r); check("R9 owner untouched", r, 16'hFFF0);
        rd(3'd4, r); check("R9 read zero", r, 16'h0000);

        // R10: no read strobe, no data
        @(negedge clk); check("R10 idle rdata", bus_rdata, 16'h0000);

        done = 1'b1;
        finish_run();
    end
endmodule